// File: doc/BRIEF.md
# DS3 M23 Frame Generator

This block produces the transmit DS3 bit stream, one bit per clock cycle. Every frame has 4760 bit times: seven subframes, each made of eight 85-bit blocks. A block starts with one overhead bit, and 84 information bits follow it. The block inserts the X, P, M, F and C overhead bits. It takes the information bits from one of two sources. The first source is seven DS2 tributary inputs, interleaved one bit at a time. The second is an external serial payload port. That port has its own toggling clock, a take-strobe and a frame sync pulse, and the sync pulse's lead ahead of the first M bit is programmable.

A mode input selects M23 framing or C-bit parity framing. A force input replaces the output with unframed all ones and holds the frame counters at the start of a frame. When the force input is released, a fresh frame begins with a cleared parity history. A loop-timing control selects the received clock reference. This selection appears as a flag that changes only on frame boundaries, and all logic runs on one clock. A monitor watches a sampled copy of the local transmit clock and raises a loss-of-clock flag when that copy stops toggling.

Control is a three-state machine:
- ST_OVH sends an overhead bit.
- ST_INFO sends information bits.
- ST_FILL sends unframed ones.

Its transitions are:
- ST_OVH to ST_INFO after one bit.
- ST_INFO to ST_OVH after the last bit of a block.
- ST_OVH or ST_INFO to ST_FILL while the force input is high.
- ST_FILL to ST_OVH when the force input drops.

Top module: `ds3_frame_gen`

## Requirements
- R1: The output stream repeats every 4760 bit times. `frame_start` is high for exactly one cycle, together with the first bit of each frame. Within each 85-bit block, bit 0 is overhead and bits 1 to 84 carry information.
- R2: The eight block-leading overhead bits of a subframe are, in order, X, F1, C1, F2, C2, F3, C3, F4. F1 and F4 are 1; F2 and F3 are 0. X is 1 in subframes 1 and 2. Subframes 3 and 4 carry P in that position. Subframes 5, 6 and 7 carry M values 0, 1 and 0.
- R3: With `payload_mode`=0, information bits come from the DS2 slots in the order slot 1 to slot 7, one bit each, restarting at slot 1 after every overhead bit. `trib_en` bit i (for slot i+1) is high alone in the cycle that bit is taken from `trib_data` bit i. That bit appears on `ds3_data` one cycle later.
- R4: `clk_sel_rx` takes the value of `loop_time_en` only when a frame starts. It changes in the same cycle in which `frame_start` goes high.
- R5: With `payload_mode`=1, information bits come from `ser_data`. `ser_en` is high in exactly the cycles in which a bit is taken, which is one cycle ahead of its output. `trib_en` stays 0. `ser_clk` inverts every cycle. With `payload_mode`=0, `ser_en` and `ser_clk` stay 0.
- R6: With `payload_mode`=1, `ser_sync` is high for one cycle per frame. That cycle lies `sync_lead` bit times (0 to 255) before the output of the first M bit, which is frame bit 2720.
- R7: With `m23_mode`=1 (M23 framing), every C bit is 0. Both P bits equal the XOR of all information bits of the previous frame.
- R8: With `m23_mode`=0 (C-bit parity framing), both P bits and the three C bits of subframe 3 equal the XOR of the previous frame's information bits. All other C bits are 0.
- R9: While `force_ones` is high, `ds3_data` is 1 from the next cycle on, and `frame_start`, `ser_sync`, `ser_en` and `trib_en` are all 0. After release there is one more fill bit, and then a new frame starts whose P bits are 0.
- R10: `tx_loc` rises after `tx_clk_mon` has held one level for 16 consecutive clock edges (parameter LOC_LIMIT). It clears on the edge after `tx_clk_mon` changes.
- R11: During reset, `ds3_data` is 1 and `frame_start`, `trib_en`, `ser_en`, `ser_sync`, `ser_clk`, `clk_sel_rx` and `tx_loc` are 0. The first bit after reset is the first bit of a frame, and its P bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one DS3 bit per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| m23_mode | input | 1 | 1 selects M23 framing, 0 selects C-bit parity framing |
| payload_mode | input | 1 | 0 takes payload from DS2 slots, 1 from the serial port |
| force_ones | input | 1 | Forces unframed all-ones output |
| loop_time_en | input | 1 | Requests the received clock reference |
| sync_lead | input | 8 | Bit times by which the sync pulse leads the first M bit |
| trib_data | input | 7 | DS2 slot bits, bit i is slot i+1 |
| ser_data | input | 1 | Serial payload bit |
| tx_clk_mon | input | 1 | Sampled level of the local transmit clock |
| ds3_data | output | 1 | Transmit DS3 bit |
| frame_start | output | 1 | Marks the first bit of each frame on ds3_data |
| trib_en | output | 7 | One-hot take-strobe per DS2 slot |
| ser_clk | output | 1 | Payload port clock |
| ser_en | output | 1 | Payload take-strobe |
| ser_sync | output | 1 | Payload frame sync pulse |
| clk_sel_rx | output | 1 | 1 when the received clock reference is in use |
| tx_loc | output | 1 | Loss of local transmit clock |

## Verification
A stale position counter or a wrong state shows at the ports within one block, that is within 85 cycles. An overhead bit lands in the wrong place, a take-strobe fires on an overhead cycle, or `frame_start` drifts away from the 4760-bit period. A wrong slot index shows on the next information bit, because the bench drives fresh random data on every slot in every cycle. A corrupted parity accumulator stays hidden until the P bits of the following frame, up to 2040 bits into that frame. A stale parity after force release shows in the first P bit of the restarted frame.

// File: rtl/ds3_fg_pkg.sv
package ds3_fg_pkg;

    // Controller states of the frame generator
    typedef enum logic [1:0] {
        ST_OVH  = 2'd0,
        ST_INFO = 2'd1,
        ST_FILL = 2'd2
    } fg_state_e;

    // Kind of overhead bit leading a block
    typedef enum logic [2:0] {
        OH_X = 3'd0,
        OH_P = 3'd1,
        OH_M = 3'd2,
        OH_F = 3'd3,
        OH_C = 3'd4
    } oh_kind_e;

endpackage

// File: rtl/ds3_pos_ctr.sv
module ds3_pos_ctr #(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 8,
    parameter int SUBFRAMES  = 7,
    parameter int SLOTS      = 7,
    localparam int FRAME_BITS = BLOCK_BITS * BLOCKS * SUBFRAMES,
    localparam int BIT_W  = $clog2(BLOCK_BITS),
    localparam int BLK_W  = $clog2(BLOCKS),
    localparam int SF_W   = $clog2(SUBFRAMES),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int POS_W  = $clog2(FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    output logic [BLK_W-1:0]  blk_idx,
    output logic [SF_W-1:0]   sf_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic [POS_W-1:0]  frame_pos,
    output logic              at_block_end,
    output logic              at_frame_end
);

    logic [BIT_W-1:0] bit_idx;
    logic             blk_last;
    logic             sf_last;

    assign at_block_end = (bit_idx == BIT_W'(BLOCK_BITS - 1));
    assign blk_last     = (blk_idx == BLK_W'(BLOCKS - 1));
    assign sf_last      = (sf_idx == SF_W'(SUBFRAMES - 1));
    assign at_frame_end = at_block_end && blk_last && sf_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx   <= '0;
            blk_idx   <= '0;
            sf_idx    <= '0;
            slot_idx  <= '0;
            frame_pos <= '0;
        end else if (clear) begin
            bit_idx   <= '0;
            blk_idx   <= '0;
            sf_idx    <= '0;
            slot_idx  <= '0;
            frame_pos <= '0;
        end else if (advance) begin
            frame_pos <= at_frame_end ? '0 : frame_pos + 1'b1;
            if (at_block_end) begin
                bit_idx <= '0;
                if (blk_last) begin
                    blk_idx <= '0;
                    sf_idx  <= sf_last ? '0 : sf_idx + 1'b1;
                end else begin
                    blk_idx <= blk_idx + 1'b1;
                end
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
            // slot index of the next information bit; overhead keeps it at 0
            if (bit_idx == '0) begin
                slot_idx <= '0;
            end else begin
                slot_idx <= (slot_idx == SLOT_W'(SLOTS - 1)) ? '0 : slot_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ds3_ovh_gen.sv
module ds3_ovh_gen
    import ds3_fg_pkg::*;
#(
    parameter int BLOCKS    = 8,
    parameter int SUBFRAMES = 7,
    localparam int BLK_W = $clog2(BLOCKS),
    localparam int SF_W  = $clog2(SUBFRAMES),
    localparam int M_FIRST_SF = SUBFRAMES - 3,
    localparam int P_FIRST_SF = M_FIRST_SF - 2,
    localparam int CPAR_SF    = P_FIRST_SF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             info_take,
    input  logic             info_bit,
    input  logic             frame_end,
    input  logic             m23_mode,
    input  logic [BLK_W-1:0] blk_idx,
    input  logic [SF_W-1:0]  sf_idx,
    output logic             ovh_bit
);

    logic     par_acc;
    logic     par_prev;
    oh_kind_e kind;
    logic [BLK_W-2:0] f_idx;

    // parity over the information bits of one frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_acc  <= 1'b0;
            par_prev <= 1'b0;
        end else if (clear) begin
            par_acc  <= 1'b0;
            par_prev <= 1'b0;
        end else if (info_take) begin
            if (frame_end) begin
                par_prev <= par_acc ^ info_bit;
                par_acc  <= 1'b0;
            end else begin
                par_acc  <= par_acc ^ info_bit;
            end
        end
    end

    assign f_idx = blk_idx[BLK_W-1:1];

    always_comb begin
        if (blk_idx == '0) begin
            if (sf_idx < SF_W'(P_FIRST_SF))      kind = OH_X;
            else if (sf_idx < SF_W'(M_FIRST_SF)) kind = OH_P;
            else                                 kind = OH_M;
        end else if (blk_idx[0]) begin
            kind = OH_F;
        end else begin
            kind = OH_C;
        end
    end

    always_comb begin
        unique case (kind)
            OH_X:    ovh_bit = 1'b1;
            OH_P:    ovh_bit = par_prev;
            OH_M:    ovh_bit = (sf_idx == SF_W'(M_FIRST_SF + 1));
            OH_F:    ovh_bit = (f_idx == '0) || (f_idx == '1);
            OH_C:    ovh_bit = !m23_mode && (sf_idx == SF_W'(CPAR_SF)) && par_prev;
            default: ovh_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/ds3_loc_mon.sv
module ds3_loc_mon #(
    parameter int LOC_LIMIT = 16,
    localparam int CNT_W = (LOC_LIMIT > 2) ? $clog2(LOC_LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_in,
    output logic loc
);

    logic             mon_prev;
    logic [CNT_W-1:0] quiet_cnt;
    logic             moved;

    assign moved = (mon_in != mon_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_prev  <= 1'b0;
            quiet_cnt <= '0;
            loc       <= 1'b0;
        end else begin
            mon_prev <= mon_in;
            if (moved) begin
                quiet_cnt <= '0;
                loc       <= 1'b0;
            end else if (quiet_cnt == CNT_W'(LOC_LIMIT - 1)) begin
                loc <= 1'b1;
            end else begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ds3_frame_gen.sv
module ds3_frame_gen
    import ds3_fg_pkg::*;
#(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 8,
    parameter int SUBFRAMES  = 7,
    parameter int SLOTS      = 7,
    parameter int LOC_LIMIT  = 16,
    parameter int LEAD_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m23_mode,
    input  logic              payload_mode,
    input  logic              force_ones,
    input  logic              loop_time_en,
    input  logic [LEAD_W-1:0] sync_lead,
    input  logic [SLOTS-1:0]  trib_data,
    input  logic              ser_data,
    input  logic              tx_clk_mon,
    output logic              ds3_data,
    output logic              frame_start,
    output logic [SLOTS-1:0]  trib_en,
    output logic              ser_clk,
    output logic              ser_en,
    output logic              ser_sync,
    output logic              clk_sel_rx,
    output logic              tx_loc
);

    localparam int SF_BITS    = BLOCK_BITS * BLOCKS;
    localparam int FRAME_BITS = SF_BITS * SUBFRAMES;
    localparam int M_POS      = (SUBFRAMES - 3) * SF_BITS;
    localparam int BLK_W  = $clog2(BLOCKS);
    localparam int SF_W   = $clog2(SUBFRAMES);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int POS_W  = $clog2(FRAME_BITS);

    fg_state_e         state_q, state_d;
    logic [BLK_W-1:0]  blk_idx;
    logic [SF_W-1:0]   sf_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic [POS_W-1:0]  frame_pos;
    logic [POS_W-1:0]  sync_pos;
    logic [POS_W-1:0]  lead_ext;
    logic              at_block_end;
    logic              at_frame_end;
    logic              filling;
    logic              info_take;
    logic              info_bit;
    logic              ovh_bit;
    logic              gen_bit;

    ds3_pos_ctr #(
        .BLOCK_BITS (BLOCK_BITS),
        .BLOCKS     (BLOCKS),
        .SUBFRAMES  (SUBFRAMES),
        .SLOTS      (SLOTS)
    ) u_pos (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (filling),
        .advance      (!filling),
        .blk_idx      (blk_idx),
        .sf_idx       (sf_idx),
        .slot_idx     (slot_idx),
        .frame_pos    (frame_pos),
        .at_block_end (at_block_end),
        .at_frame_end (at_frame_end)
    );

    ds3_ovh_gen #(
        .BLOCKS    (BLOCKS),
        .SUBFRAMES (SUBFRAMES)
    ) u_ovh (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (filling),
        .info_take (info_take),
        .info_bit  (info_bit),
        .frame_end (at_frame_end),
        .m23_mode  (m23_mode),
        .blk_idx   (blk_idx),
        .sf_idx    (sf_idx),
        .ovh_bit   (ovh_bit)
    );

    ds3_loc_mon #(
        .LOC_LIMIT (LOC_LIMIT)
    ) u_loc (
        .clk    (clk),
        .rst_n  (rst_n),
        .mon_in (tx_clk_mon),
        .loc    (tx_loc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OVH;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OVH:  state_d = force_ones ? ST_FILL : ST_INFO;
            ST_INFO: begin
                if (force_ones)        state_d = ST_FILL;
                else if (at_block_end) state_d = ST_OVH;
                else                   state_d = ST_INFO;
            end
            ST_FILL: state_d = force_ones ? ST_FILL : ST_OVH;
            default: state_d = ST_OVH;
        endcase
    end

    // bit selection and take-strobes
    always_comb begin
        filling   = force_ones || (state_q == ST_FILL);
        info_take = (state_q == ST_INFO) && !force_ones;
        info_bit  = payload_mode ? ser_data : trib_data[slot_idx];
        gen_bit   = (state_q == ST_INFO) ? info_bit : ovh_bit;
        ser_en    = info_take && payload_mode;
        trib_en   = (info_take && !payload_mode) ? (SLOTS'(1) << slot_idx) : '0;
        lead_ext  = POS_W'(sync_lead);
        if (lead_ext <= POS_W'(M_POS)) sync_pos = POS_W'(M_POS) - lead_ext;
        else                           sync_pos = POS_W'(M_POS + FRAME_BITS) - lead_ext;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ds3_data    <= 1'b1;
            frame_start <= 1'b0;
            ser_sync    <= 1'b0;
            ser_clk     <= 1'b0;
            clk_sel_rx  <= 1'b0;
        end else begin
            ds3_data    <= filling ? 1'b1 : gen_bit;
            frame_start <= !filling && (state_q == ST_OVH) && (frame_pos == '0);
            ser_sync    <= !filling && payload_mode && (frame_pos == sync_pos);
            ser_clk     <= payload_mode ? !ser_clk : 1'b0;
            if (frame_pos == '0) clk_sel_rx <= loop_time_en;
        end
    end

endmodule

// File: rtl/ds3_fg_chk.sv
module ds3_fg_chk #(
    parameter int SLOTS = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             payload_mode,
    input logic             force_ones,
    input logic             loop_time_en,
    input logic             tx_clk_mon,
    input logic             ds3_data,
    input logic             frame_start,
    input logic [SLOTS-1:0] trib_en,
    input logic             ser_en,
    input logic             ser_sync,
    input logic             clk_sel_rx,
    input logic             tx_loc
);

    assert_frame_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trib_en));

    assert_clk_sel_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (clk_sel_rx == $past(loop_time_en)));

    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |-> (payload_mode && (trib_en == '0)));

    assert_sync_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sync |-> $past(payload_mode));

    assert_force_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_ones |=> (ds3_data && !frame_start && !ser_sync));

    assert_loc_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clk_mon != $past(tx_clk_mon)) |=> !tx_loc);

endmodule

bind ds3_frame_gen ds3_fg_chk #(.SLOTS(SLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .payload_mode (payload_mode),
    .force_ones   (force_ones),
    .loop_time_en (loop_time_en),
    .tx_clk_mon   (tx_clk_mon),
    .ds3_data     (ds3_data),
    .frame_start  (frame_start),
    .trib_en      (trib_en),
    .ser_en       (ser_en),
    .ser_sync     (ser_sync),
    .clk_sel_rx   (clk_sel_rx),
    .tx_loc       (tx_loc)
);

// File: tb/test_ds3_frame_gen.sv
`timescale 1ns/1ps
module test_ds3_frame_gen;

    localparam int BB    = 85;
    localparam int NB    = 8;
    localparam int NSF   = 7;
    localparam int NS    = 7;
    localparam int LOC_L = 16;
    localparam int SFB   = BB * NB;
    localparam int FRAME = SFB * NSF;
    localparam int MPOS  = 4 * SFB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m23_mode = 1'b1;
    logic          payload_mode = 1'b0;
    logic          force_ones = 1'b0;
    logic          loop_time_en = 1'b0;
    logic [7:0]    sync_lead = 8'd0;
    logic [NS-1:0] trib_data = '0;
    logic          ser_data = 1'b0;
    logic          tx_clk_mon = 1'b0;
    logic          ds3_data, frame_start, ser_clk, ser_en, ser_sync, clk_sel_rx, tx_loc;
    logic [NS-1:0] trib_en;

    int            checks = 0;
    int            errors = 0;
    bit            mon_toggle = 1'b1;
    logic [31:0]   rng = 32'h1234_5678;
    logic          last_ser = 1'b0;
    logic [NS-1:0] last_trib = '0;

    always #2.5 clk = ~clk;

    ds3_frame_gen i_ds3_frame_gen (
        .clk(clk), .rst_n(rst_n), .m23_mode(m23_mode), .payload_mode(payload_mode),
        .force_ones(force_ones), .loop_time_en(loop_time_en), .sync_lead(sync_lead),
        .trib_data(trib_data), .ser_data(ser_data), .tx_clk_mon(tx_clk_mon),
        .ds3_data(ds3_data), .frame_start(frame_start), .trib_en(trib_en),
        .ser_clk(ser_clk), .ser_en(ser_en), .ser_sync(ser_sync),
        .clk_sel_rx(clk_sel_rx), .tx_loc(tx_loc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // drive fresh inputs, then move to the next sample point
    task automatic step();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        ser_data  = rng[0];
        trib_data = rng[9:3];
        if (mon_toggle) tx_clk_mon = ~tx_clk_mon;
        last_ser  = ser_data;
        last_trib = trib_data;
        @(negedge clk);
    endtask

    task automatic apply_reset(input bit m23, input bit pay, input logic [7:0] lead,
                               input bit loopt);
        @(negedge clk);
        rst_n        = 1'b0;
        m23_mode     = m23;
        payload_mode = pay;
        sync_lead    = lead;
        loop_time_en = loopt;
        force_ones   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic exp_ovh(input int pos, input bit m23, input bit par);
        int blk = (pos / BB) % NB;
        int sf  = pos / SFB;
        if (blk == 0) begin
            if (sf < 2) return 1'b1;
            if (sf < 4) return par;
            return (sf == 5);
        end
        if (blk == 1 || blk == 7) return 1'b1;
        if (blk == 3 || blk == 5) return 1'b0;
        if (m23) return 1'b0;
        return (sf == 2) ? par : 1'b0;
    endfunction

    // follow the stream from the next frame start for nframes frames
    task automatic stream_check(input int nframes, input string req);
        int guard = 0;
        bit par = 1'b0;
        bit acc = 1'b0;
        logic prev_sclk;
        step();
        while (frame_start !== 1'b1 && guard < FRAME + 10) begin
            step();
            guard++;
        end
        if (frame_start !== 1'b1) begin
            check(1'b0, req, "frame start not found", 0, 1);
            return;
        end
        prev_sclk = ser_clk;
        for (int f = 0; f < nframes; f++) begin
            int bad = 0, sbad = 0, fpos = -1, fact = 0, fexp = 0;
            for (int pos = 0; pos < FRAME; pos++) begin
                int  b    = pos % BB;
                int  np   = (pos + 1) % FRAME;
                int  nb   = np % BB;
                bit  e;
                logic [NS-1:0] etrib;
                bit  eser;
                if (!(f == 0 && pos == 0)) step();
                if (b != 0) begin
                    e = payload_mode ? last_ser : last_trib[(b - 1) % NS];
                    acc = acc ^ e;
                end else begin
                    e = exp_ovh(pos, m23_mode, par);
                end
                if (ds3_data !== e) begin
                    bad++;
                    if (fpos < 0) begin fpos = pos; fact = int'(ds3_data); fexp = int'(e); end
                end
                etrib = (nb != 0 && !payload_mode) ? NS'(1) << ((nb - 1) % NS) : '0;
                eser  = (nb != 0) && payload_mode;
                if (frame_start !== (pos == 0)) sbad++;
                if (ser_sync !== (payload_mode && pos == MPOS - int'(sync_lead))) sbad++;
                if (trib_en !== etrib || ser_en !== eser) sbad++;
                if (payload_mode && pos > 0 && ser_clk === prev_sclk) sbad++;
                if (!payload_mode && ser_clk !== 1'b0) sbad++;
                prev_sclk = ser_clk;
                if (pos == FRAME - 1) begin
                    par = acc;
                    acc = 1'b0;
                end
            end
            if (bad != 0)
                $display("  first data mismatch at frame bit %0d", fpos);
            check(bad == 0, req, "frame bit stream", fact, fexp);
            check(sbad == 0, req, "strobe/sync/start mismatches", sbad, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(ds3_data === 1'b1, "R11", "ds3_data in reset", int'(ds3_data), 1);
        check(frame_start === 1'b0 && ser_sync === 1'b0, "R11", "frame_start/ser_sync in reset",
              int'({frame_start, ser_sync}), 0);
        check(trib_en === '0 && ser_en === 1'b0, "R11", "strobes in reset",
              int'({trib_en, ser_en}), 0);
        check(ser_clk === 1'b0 && clk_sel_rx === 1'b0 && tx_loc === 1'b0, "R11",
              "ser_clk/clk_sel_rx/tx_loc in reset", int'({ser_clk, clk_sel_rx, tx_loc}), 0);
        rst_n = 1'b1;
        step();
        check(frame_start === 1'b1 && ds3_data === 1'b1, "R11", "first bit after reset is X",
              int'({frame_start, ds3_data}), 3);
    endtask

    task automatic t_ds2_m23();
        apply_reset(1'b1, 1'b0, 8'd0, 1'b0);
        stream_check(2, "R1 R2 R3 R7");
    endtask

    task automatic t_ds2_cbit();
        apply_reset(1'b0, 1'b0, 8'd0, 1'b0);
        stream_check(2, "R8");
    endtask

    task automatic t_payload();
        apply_reset(1'b1, 1'b1, 8'd37, 1'b0);
        stream_check(2, "R5 R6");
    endtask

    task automatic t_lead_bounds();
        apply_reset(1'b0, 1'b1, 8'd0, 1'b0);
        stream_check(1, "R6 lead 0");
        apply_reset(1'b0, 1'b1, 8'd255, 1'b0);
        stream_check(1, "R6 lead 255");
    endtask

    task automatic t_force();
        int bad = 0;
        apply_reset(1'b0, 1'b0, 8'd0, 1'b0);
        stream_check(1, "R8");
        repeat (300) step();
        force_ones = 1'b1;
        for (int i = 0; i < 64; i++) begin
            step();
            if (ds3_data !== 1'b1 || frame_start !== 1'b0 || trib_en !== '0 ||
                ser_en !== 1'b0 || ser_sync !== 1'b0) bad++;
        end
        check(bad == 0, "R9", "forced all-ones cycles with wrong outputs", bad, 0);
        force_ones = 1'b0;
        step();
        check(ds3_data === 1'b1 && frame_start === 1'b0, "R9", "fill bit after release",
              int'({ds3_data, frame_start}), 2);
        stream_check(1, "R9 restart");
    endtask

    task automatic t_clk_sel();
        int guard = 0;
        apply_reset(1'b1, 1'b0, 8'd0, 1'b0);
        step();
        check(clk_sel_rx === 1'b0, "R4", "clk_sel_rx at first frame", int'(clk_sel_rx), 0);
        repeat (1000) step();
        loop_time_en = 1'b1;
        repeat (100) step();
        check(clk_sel_rx === 1'b0, "R4", "clk_sel_rx held mid-frame", int'(clk_sel_rx), 0);
        while (frame_start !== 1'b1 && guard < FRAME + 10) begin
            step();
            guard++;
        end
        check(frame_start === 1'b1 && clk_sel_rx === 1'b1, "R4", "clk_sel_rx at frame start",
              int'({frame_start, clk_sel_rx}), 3);
    endtask

    task automatic t_loc();
        apply_reset(1'b1, 1'b0, 8'd0, 1'b0);
        mon_toggle = 1'b1;
        repeat (50) step();
        check(tx_loc === 1'b0, "R10", "tx_loc with active clock", int'(tx_loc), 0);
        mon_toggle = 1'b0;
        repeat (LOC_L - 1) step();
        check(tx_loc === 1'b0, "R10", "tx_loc before limit", int'(tx_loc), 0);
        step();
        check(tx_loc === 1'b1, "R10", "tx_loc at limit", int'(tx_loc), 1);
        mon_toggle = 1'b1;
        step();
        check(tx_loc === 1'b0, "R10", "tx_loc after activity returns", int'(tx_loc), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_ds2_m23();
        t_ds2_cbit();
        t_payload();
        t_lead_bounds();
        t_force();
        t_clk_sel();
        t_loc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule